// File: doc/BRIEF.md
# Framebuffer control register file

This block is the 32-bit memory-mapped control bank of an 8-bit indexed-colour framebuffer controller. A host performs full-word reads and writes on a simple single-cycle bus. The block keeps the display geometry, a control word, the base address of the visible screen, a 256-entry colour palette, a 3-entry cursor palette, a 512-word cursor pattern and the cursor position. A downstream pixel pipeline reads this state through direct outputs and through combinational lookup ports.

The display width and height are held in scaled form. The width is four times the value written, and the height is half the value written. Table entries sit one per 8-byte slot. The control word carries a forced-blank flag, a cursor-disable flag and a 3-bit colour-depth code, and the block decodes that code into bits per pixel. The pipeline signals each finished frame with a pulse, and that pulse raises the interrupt. Any bus write lowers the interrupt again. A one-cycle dirty pulse tells the pipeline that state affecting the picture has changed. A write to a soft-reset address clears all stored state.

Top module: `fbc_regfile`

## Requirements
- R1: A write to offset 0x118 sets `disp_width` to the written value times 4, truncated to DIM_W bits. A read of 0x118 returns the stored width divided by 4.
- R2: A write to offset 0x150 sets `disp_height` to the written value divided by 2, rounded down. A read of 0x150 returns the stored height times 2, so an odd written value reads back one lower.
- R3: A write to offset 0x300 stores the whole control word, and a read of 0x300 returns it. Bit 10 drives `force_blank` and bit 23 drives `cursor_off`.
- R4: `depth_bpp` decodes control bits 22:20. Codes 0 to 7 give 1, 2, 4, 8, 15, 16, 0 and 0 bits per pixel.
- R5: The colour palette covers 0x800 to 0xFFF. Entry n sits at 0x800 + 8n, and the byte offset within the slot is ignored. Written bits 23:16, 15:8 and 7:0 are red, green and blue, and `pal_rgb` returns them packed the same way for `pal_idx`. A bus read of the palette returns zero.
- R6: The cursor palette has entries 0, 1 and 2 at 0x508, 0x510 and 0x518, with the same RGB packing. Bus reads return the packed value. `cpal_rgb` returns the entry chosen by `cpal_sel`, and a select of 3 returns zero.
- R7: The cursor pattern covers 0x1000 to 0x1FFF. Word n sits at 0x1000 + 8n and stores written bits 15:0. Reads return that word with zero extension, and `pat_word` returns word `pat_idx`.
- R8: A write to 0x400 sets `top_base` to the full written word. A write to 0x638 sets the cursor position: `cur_x` is written bits 23:12 and `cur_y` is written bits 11:0. Reads of both offsets return zero.
- R9: A write to 0x100000 clears the width, height, control word, top base, cursor position, both palettes and the pattern, and lowers `irq`.
- R10: Writes to the timing offsets 0x000, 0x200, and 0x108 to 0x170 on 8-byte steps (apart from 0x118 and 0x150) change nothing. Writes to other unmapped offsets also change nothing. Reads of unmapped offsets return zero.
- R11: A `frame_done` pulse with no write in the same cycle sets `irq` in the next cycle. Every write clears `irq` in the next cycle, and a write wins over a `frame_done` in the same cycle.
- R12: `dirty` is high for the one cycle after a write to the colour palette, cursor palette, pattern, control word, top base, cursor position or soft-reset address. It stays low after writes to the width, height, timing or unmapped offsets.
- R13: `bus_rdata` is registered. It shows the addressed value in the cycle after `bus_rd` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (21) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frame_done | input | 1 | Pulse from the pixel pipeline at the end of a frame |
| irq | output | 1 | Frame interrupt |
| dirty | output | 1 | One-cycle pulse when state affecting the picture changed |
| disp_width | output | DIM_W (16) | Width in pixels |
| disp_height | output | DIM_W (16) | Height in lines |
| ctrl_word | output | 32 | Stored control word |
| force_blank | output | 1 | Blank the screen |
| cursor_off | output | 1 | Hide the cursor |
| depth_bpp | output | 5 | Decoded bits per pixel |
| top_base | output | 32 | Base address of the visible screen |
| cur_x | output | 12 | Cursor column |
| cur_y | output | 12 | Cursor row |
| pal_idx | input | 8 | Colour palette lookup index |
| pal_rgb | output | 24 | Colour palette entry |
| cpal_sel | input | 2 | Cursor palette lookup select |
| cpal_rgb | output | 24 | Cursor palette entry |
| pat_idx | input | 9 | Cursor pattern lookup index |
| pat_word | output | 16 | Cursor pattern word |

## Verification
The interrupt has two sources that can meet in one cycle: a `frame_done` pulse sets it, and a bus write clears it. The bench first raises `irq` with a lone frame pulse. It then asserts a write and a frame pulse on the same clock edge and requires `irq` to be low in the following cycle, because the write has priority. A lone frame pulse afterwards must raise `irq` again, which shows that the earlier low came from the priority rule and not from a stuck line.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  localparam logic [31:0] OFF_WIDTH  = 32'h0000_0118;
  localparam logic [31:0] OFF_HEIGHT = 32'h0000_0150;
  localparam logic [31:0] OFF_CTRL   = 32'h0000_0300;
  localparam logic [31:0] OFF_TOP    = 32'h0000_0400;
  localparam logic [31:0] OFF_CPAL   = 32'h0000_0508;
  localparam logic [31:0] OFF_CPOS   = 32'h0000_0638;
  localparam logic [31:0] OFF_PAL    = 32'h0000_0800;
  localparam logic [31:0] OFF_PAT    = 32'h0000_1000;
  localparam logic [31:0] OFF_SRST   = 32'h0010_0000;

  // control word fields
  localparam int BLANK_BIT   = 10;
  localparam int NOCURS_BIT  = 23;
  localparam int DEPTH_LSB   = 20;

  typedef enum logic [3:0] {
    RG_NONE, RG_WIDTH, RG_HEIGHT, RG_CTRL, RG_TOP, RG_CPOS,
    RG_CPAL, RG_PAL, RG_PAT, RG_SRST, RG_TIMING
  } fbc_region_e;

  // bits per pixel for a 3-bit depth code
  function automatic logic [4:0] fbc_depth_bpp(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  // timing and memory-cycle slots that accept and drop writes
  function automatic logic fbc_is_timing(input logic [31:0] a);
    return (a == 32'h0) || (a == 32'h200) ||
           (a >= 32'h108 && a <= 32'h170 && a[2:0] == 3'b000 &&
            a != OFF_WIDTH && a != OFF_HEIGHT);
  endfunction

endpackage

// File: rtl/fbc_decode.sv
module fbc_decode
  import fbc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int PAL_N  = 256,
  parameter int CPAL_N = 3,
  parameter int PAT_N  = 512,
  parameter int SLOT_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output fbc_region_e       region,
  output logic [SLOT_W-1:0] slot
);

  localparam logic [31:0] PAL_END  = OFF_PAL  + 32'(PAL_N * 8);
  localparam logic [31:0] CPAL_END = OFF_CPAL + 32'(CPAL_N * 8);
  localparam logic [31:0] PAT_END  = OFF_PAT  + 32'(PAT_N * 8);

  logic [31:0] a32;
  logic [31:0] rel;

  assign a32 = 32'(addr);

  always_comb begin
    region = RG_NONE;
    rel    = '0;
    if (a32 >= OFF_PAL && a32 < PAL_END) begin
      region = RG_PAL;
      rel    = a32 - OFF_PAL;
    end else if (a32 >= OFF_PAT && a32 < PAT_END) begin
      region = RG_PAT;
      rel    = a32 - OFF_PAT;
    end else if (a32 >= OFF_CPAL && a32 < CPAL_END) begin
      region = RG_CPAL;
      rel    = a32 - OFF_CPAL;
    end else if (a32 == OFF_WIDTH)  region = RG_WIDTH;
    else if (a32 == OFF_HEIGHT)     region = RG_HEIGHT;
    else if (a32 == OFF_CTRL)       region = RG_CTRL;
    else if (a32 == OFF_TOP)        region = RG_TOP;
    else if (a32 == OFF_CPOS)       region = RG_CPOS;
    else if (a32 == OFF_SRST)       region = RG_SRST;
    else if (fbc_is_timing(a32))    region = RG_TIMING;
  end

  // one table entry per 8-byte slot
  assign slot = SLOT_W'(rel >> 3);

endmodule

// File: rtl/fbc_lut.sv
module fbc_lut #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (clr)                            q <= '0;
      else if (we && waddr == AW'(e))          q <= wdata;
    end
    assign ent[e] = q;
  end

  if (DEPTH == (1 << AW)) begin : g_full
    assign rdata_a = ent[raddr_a];
    assign rdata_b = ent[raddr_b];
  end else begin : g_part
    assign rdata_a = (raddr_a < AW'(DEPTH)) ? ent[raddr_a] : '0;
    assign rdata_b = (raddr_b < AW'(DEPTH)) ? ent[raddr_b] : '0;
  end

  // R9: a clear empties every entry seen on the bus port
  a_r9_lut_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rdata_a == '0));

endmodule

// File: rtl/fbc_regfile.sv
module fbc_regfile
  import fbc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DIM_W  = 16,
  parameter int PAL_N  = 256,
  parameter int CPAL_N = 3,
  parameter int PAT_N  = 512,
  parameter int PAT_W  = 16,
  parameter int CLR_W  = 24,
  parameter int PAL_AW  = $clog2(PAL_N),
  parameter int CPAL_AW = $clog2(CPAL_N),
  parameter int PAT_AW  = $clog2(PAT_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               frame_done,
  output logic               irq,
  output logic               dirty,
  output logic [DIM_W-1:0]   disp_width,
  output logic [DIM_W-1:0]   disp_height,
  output logic [31:0]        ctrl_word,
  output logic               force_blank,
  output logic               cursor_off,
  output logic [4:0]         depth_bpp,
  output logic [31:0]        top_base,
  output logic [11:0]        cur_x,
  output logic [11:0]        cur_y,
  input  logic [PAL_AW-1:0]  pal_idx,
  output logic [CLR_W-1:0]   pal_rgb,
  input  logic [CPAL_AW-1:0] cpal_sel,
  output logic [CLR_W-1:0]   cpal_rgb,
  input  logic [PAT_AW-1:0]  pat_idx,
  output logic [PAT_W-1:0]   pat_word
);

  localparam int SLOT_W = (PAT_AW > PAL_AW) ? PAT_AW : PAL_AW;

  // ---- scaling arithmetic, kept in one place
  function automatic logic [DIM_W-1:0] width_in(input logic [31:0] v);
    return DIM_W'(v << 2);
  endfunction
  function automatic logic [31:0] width_out(input logic [DIM_W-1:0] w);
    return 32'(w >> 2);
  endfunction
  function automatic logic [DIM_W-1:0] height_in(input logic [31:0] v);
    return DIM_W'(v >> 1);
  endfunction
  function automatic logic [31:0] height_out(input logic [DIM_W-1:0] h);
    return 32'(h) << 1;
  endfunction

  // ---- decode
  fbc_region_e       region;
  logic [SLOT_W-1:0] slot;

  fbc_decode #(
    .ADDR_W(ADDR_W), .PAL_N(PAL_N), .CPAL_N(CPAL_N),
    .PAT_N(PAT_N), .SLOT_W(SLOT_W)
  ) u_dec (
    .addr(bus_addr), .region(region), .slot(slot)
  );

  // ---- named write events
  logic ev_width, ev_height, ev_ctrl, ev_top, ev_cpos;
  logic ev_pal, ev_cpal, ev_pat, ev_srst, ev_visual;

  assign ev_width  = bus_wr && (region == RG_WIDTH);
  assign ev_height = bus_wr && (region == RG_HEIGHT);
  assign ev_ctrl   = bus_wr && (region == RG_CTRL);
  assign ev_top    = bus_wr && (region == RG_TOP);
  assign ev_cpos   = bus_wr && (region == RG_CPOS);
  assign ev_pal    = bus_wr && (region == RG_PAL);
  assign ev_cpal   = bus_wr && (region == RG_CPAL);
  assign ev_pat    = bus_wr && (region == RG_PAT);
  assign ev_srst   = bus_wr && (region == RG_SRST);
  assign ev_visual = ev_ctrl | ev_top | ev_cpos | ev_pal | ev_cpal |
                     ev_pat | ev_srst;

  // ---- scalar registers
  logic [DIM_W-1:0] width_q, height_q;
  logic [31:0]      ctrl_q, top_q;
  logic [23:0]      cpos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      height_q <= '0;
      ctrl_q   <= '0;
      top_q    <= '0;
      cpos_q   <= '0;
    end else if (ev_srst) begin
      width_q  <= '0;
      height_q <= '0;
      ctrl_q   <= '0;
      top_q    <= '0;
      cpos_q   <= '0;
    end else begin
      if (ev_width)  width_q  <= width_in(bus_wdata);
      if (ev_height) height_q <= height_in(bus_wdata);
      if (ev_ctrl)   ctrl_q   <= bus_wdata;
      if (ev_top)    top_q    <= bus_wdata;
      if (ev_cpos)   cpos_q   <= bus_wdata[23:0];
    end
  end

  // ---- tables
  logic [CLR_W-1:0] pal_bus_rd, cpal_bus_rd;
  logic [PAT_W-1:0] pat_bus_rd;

  fbc_lut #(.DEPTH(PAL_N), .DW(CLR_W), .AW(PAL_AW)) u_pal (
    .clk(clk), .rst_n(rst_n), .clr(ev_srst), .we(ev_pal),
    .waddr(slot[PAL_AW-1:0]), .wdata(bus_wdata[CLR_W-1:0]),
    .raddr_a(slot[PAL_AW-1:0]), .rdata_a(pal_bus_rd),
    .raddr_b(pal_idx), .rdata_b(pal_rgb)
  );

  fbc_lut #(.DEPTH(CPAL_N), .DW(CLR_W), .AW(CPAL_AW)) u_cpal (
    .clk(clk), .rst_n(rst_n), .clr(ev_srst), .we(ev_cpal),
    .waddr(slot[CPAL_AW-1:0]), .wdata(bus_wdata[CLR_W-1:0]),
    .raddr_a(slot[CPAL_AW-1:0]), .rdata_a(cpal_bus_rd),
    .raddr_b(cpal_sel), .rdata_b(cpal_rgb)
  );

  fbc_lut #(.DEPTH(PAT_N), .DW(PAT_W), .AW(PAT_AW)) u_pat (
    .clk(clk), .rst_n(rst_n), .clr(ev_srst), .we(ev_pat),
    .waddr(slot[PAT_AW-1:0]), .wdata(bus_wdata[PAT_W-1:0]),
    .raddr_a(slot[PAT_AW-1:0]), .rdata_a(pat_bus_rd),
    .raddr_b(pat_idx), .rdata_b(pat_word)
  );

  // colour palette is write-only from the bus
  logic pal_rd_unused;
  assign pal_rd_unused = ^pal_bus_rd;

  // ---- read path
  logic [31:0] rd_mux;

  always_comb begin
    case (region)
      RG_WIDTH:  rd_mux = width_out(width_q);
      RG_HEIGHT: rd_mux = height_out(height_q);
      RG_CTRL:   rd_mux = ctrl_q;
      RG_CPAL:   rd_mux = 32'(cpal_bus_rd);
      RG_PAT:    rd_mux = 32'(pat_bus_rd);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= rd_mux;
  end

  // ---- interrupt and dirty pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      dirty <= 1'b0;
    end else begin
      dirty <= ev_visual;
      if (bus_wr)          irq <= 1'b0;
      else if (frame_done) irq <= 1'b1;
    end
  end

  // ---- exports
  assign disp_width  = width_q;
  assign disp_height = height_q;
  assign ctrl_word   = ctrl_q;
  assign force_blank = ctrl_q[BLANK_BIT];
  assign cursor_off  = ctrl_q[NOCURS_BIT];
  assign depth_bpp   = fbc_depth_bpp(ctrl_q[DEPTH_LSB +: 3]);
  assign top_base    = top_q;
  assign cur_x       = cpos_q[23:12];
  assign cur_y       = cpos_q[11:0];

  // ---- assertions
  // R11: a write always leaves the interrupt low
  a_r11_write_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !irq);

  // R11: a lone frame pulse raises the interrupt
  a_r11_frame_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !bus_wr) |=> irq);

  // R12: dirty only follows a write
  a_r12_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    dirty |-> $past(bus_wr));

  // R9: soft reset empties the scalar state
  a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_srst |=> (disp_width == '0 && disp_height == '0 &&
                 ctrl_word == '0 && top_base == '0 && cur_x == '0));

  // R10: timing slots leave state and dirty untouched
  a_r10_timing_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && region == RG_TIMING) |=>
      ($stable(ctrl_word) && $stable(disp_width) && !dirty));

  // R13: read data holds without a read strobe
  a_r13_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_fbc_regfile.sv
`timescale 1ns/1ps
module sim_fbc_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [20:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_done = 1'b0;
  logic        irq, dirty, force_blank, cursor_off;
  logic [15:0] disp_width, disp_height;
  logic [31:0] ctrl_word, top_base;
  logic [4:0]  depth_bpp;
  logic [11:0] cur_x, cur_y;
  logic [7:0]  pal_idx = '0;
  logic [23:0] pal_rgb, cpal_rgb;
  logic [1:0]  cpal_sel = '0;
  logic [8:0]  pat_idx = '0;
  logic [15:0] pat_word;

  always #4 clk = ~clk;

  fbc_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_done(frame_done), .irq(irq), .dirty(dirty),
    .disp_width(disp_width), .disp_height(disp_height),
    .ctrl_word(ctrl_word), .force_blank(force_blank),
    .cursor_off(cursor_off), .depth_bpp(depth_bpp), .top_base(top_base),
    .cur_x(cur_x), .cur_y(cur_y), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .cpal_sel(cpal_sel), .cpal_rgb(cpal_rgb), .pat_idx(pat_idx),
    .pat_word(pat_word)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [20:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  typedef struct packed {
    logic [20:0] addr;
    logic [31:0] wval;
    logic [31:0] rexp;
    logic        dexp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{21'h000118, 32'h0000_0140, 32'h0000_0140, 1'b0, 4'd1},  // R1
    '{21'h000150, 32'h0000_01E1, 32'h0000_01E0, 1'b0, 4'd2},  // R2 odd value
    '{21'h000300, 32'h00B0_0400, 32'h00B0_0400, 1'b1, 4'd3},  // R3
    '{21'h000510, 32'h00A1_B2C3, 32'h00A1_B2C3, 1'b1, 4'd6},  // R6
    '{21'h001FF8, 32'hDEAD_BEEF, 32'h0000_BEEF, 1'b1, 4'd7},  // R7 last word
    '{21'h000808, 32'h0011_2233, 32'h0000_0000, 1'b1, 4'd5},  // R5 reads zero
    '{21'h000400, 32'h0001_2000, 32'h0000_0000, 1'b1, 4'd8},  // R8
    '{21'h000638, 32'h0012_3456, 32'h0000_0000, 1'b1, 4'd8},  // R8
    '{21'h000108, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd10}, // R10 timing
    '{21'h000704, 32'h0000_5555, 32'h0000_0000, 1'b0, 4'd10}  // R10 unmapped
  };

  localparam logic [4:0] BPP [8] = '{5'd1, 5'd2, 5'd4, 5'd8,
                                     5'd15, 5'd16, 5'd0, 5'd0};

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R9, R11, R12, R4)
    chk(disp_width == 0, "R9 reset width", 32'(disp_width), 0);
    chk(ctrl_word == 0, "R9 reset ctrl", ctrl_word, 0);
    chk(irq == 0, "R11 reset irq", 32'(irq), 0);
    chk(dirty == 0, "R12 reset dirty", 32'(dirty), 0);
    chk(depth_bpp == 5'd1, "R4 reset depth", 32'(depth_bpp), 1);

    // vector table: write, check dirty, read back
    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].addr, VECS[i].wval);
      chk(dirty == VECS[i].dexp, $sformatf("R12 dirty vec%0d R%0d", i, VECS[i].req),
          32'(dirty), 32'(VECS[i].dexp));
      do_read(VECS[i].addr, rd);
      chk(rd == VECS[i].rexp, $sformatf("R13 read vec%0d R%0d", i, VECS[i].req),
          rd, VECS[i].rexp);
    end

    // exported values after the table
    chk(disp_width == 16'h0500, "R1 width scaled", 32'(disp_width), 32'h500);
    chk(disp_height == 16'h00F0, "R2 height scaled", 32'(disp_height), 32'hF0);
    chk(force_blank == 1'b1, "R3 blank bit", 32'(force_blank), 1);
    chk(cursor_off == 1'b1, "R3 cursor bit", 32'(cursor_off), 1);
    chk(depth_bpp == 5'd8, "R4 code 3", 32'(depth_bpp), 8);
    chk(top_base == 32'h12000, "R8 top", top_base, 32'h12000);
    chk(cur_x == 12'h123, "R8 cur_x", 32'(cur_x), 32'h123);
    chk(cur_y == 12'h456, "R8 cur_y", 32'(cur_y), 32'h456);
    chk(ctrl_word == 32'h00B00400, "R10 timing write ignored", ctrl_word, 32'h00B00400);

    // lookup ports
    @(negedge clk);
    pal_idx = 8'd1; cpal_sel = 2'd1; pat_idx = 9'd511;
    #1;
    chk(pal_rgb == 24'h112233, "R5 pal entry 1", 32'(pal_rgb), 32'h112233);
    chk(cpal_rgb == 24'hA1B2C3, "R6 cpal entry 1", 32'(cpal_rgb), 32'hA1B2C3);
    chk(pat_word == 16'hBEEF, "R7 pattern 511", 32'(pat_word), 32'hBEEF);

    do_write(21'h000FF8, 32'hFF_7F_3F_1F);   // R5 last entry, top byte dropped
    do_write(21'h00080C, 32'h00AB_CDEF);     // R5 offset 4 inside slot 1
    do_write(21'h000508, 32'h0001_0203);     // R6 entry 0
    do_write(21'h000518, 32'h0004_0506);     // R6 entry 2
    pal_idx = 8'd255; cpal_sel = 2'd0; #1;
    chk(pal_rgb == 24'h7F3F1F, "R5 pal entry 255", 32'(pal_rgb), 32'h7F3F1F);
    chk(cpal_rgb == 24'h010203, "R6 cpal entry 0", 32'(cpal_rgb), 32'h010203);
    pal_idx = 8'd1; cpal_sel = 2'd2; #1;
    chk(pal_rgb == 24'hABCDEF, "R5 slot offset ignored", 32'(pal_rgb), 32'hABCDEF);
    chk(cpal_rgb == 24'h040506, "R6 cpal entry 2", 32'(cpal_rgb), 32'h040506);
    cpal_sel = 2'd3; #1;
    chk(cpal_rgb == 24'h0, "R6 cpal select 3", 32'(cpal_rgb), 0);
    do_read(21'h000518, rd);
    chk(rd == 32'h00040506, "R6 cpal read", rd, 32'h00040506);

    // depth codes
    for (int k = 0; k < 8; k++) begin
      do_write(21'h000300, 32'(k) << 20);
      chk(depth_bpp == BPP[k], $sformatf("R4 depth code %0d", k),
          32'(depth_bpp), 32'(BPP[k]));
    end
    chk(force_blank == 0 && cursor_off == 0, "R3 flags cleared",
        32'({force_blank, cursor_off}), 0);

    // read data hold
    do_read(21'h000118, rd);
    @(negedge clk);
    bus_addr = 21'h000300;
    @(negedge clk);
    chk(bus_rdata == 32'h140, "R13 rdata holds", bus_rdata, 32'h140);

    // interrupt
    frame_pulse();
    chk(irq == 1'b1, "R11 frame sets irq", 32'(irq), 1);
    do_write(21'h000200, 32'h1234);
    chk(irq == 1'b0, "R11 write clears irq", 32'(irq), 0);
    chk(dirty == 1'b0, "R12 timing no dirty", 32'(dirty), 0);
    frame_pulse();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 21'h000000; bus_wdata = 32'h0; frame_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; frame_done = 1'b0;
    chk(irq == 1'b0, "R11 write wins over frame", 32'(irq), 0);
    frame_pulse();
    chk(irq == 1'b1, "R11 frame after clash", 32'(irq), 1);

    // soft reset
    do_write(21'h100000, 32'h0);
    chk(irq == 1'b0, "R9 irq lowered", 32'(irq), 0);
    chk(dirty == 1'b1, "R12 srst dirty", 32'(dirty), 1);
    chk(disp_width == 0 && disp_height == 0, "R9 geometry cleared",
        32'({disp_width, disp_height}), 0);
    chk(top_base == 0 && cur_x == 0 && cur_y == 0, "R9 top/cursor cleared",
        top_base, 0);
    pal_idx = 8'd1; cpal_sel = 2'd2; pat_idx = 9'd511; #1;
    chk(pal_rgb == 0, "R9 palette cleared", 32'(pal_rgb), 0);
    chk(cpal_rgb == 0, "R9 cursor palette cleared", 32'(cpal_rgb), 0);
    chk(pat_word == 0, "R9 pattern cleared", 32'(pat_word), 0);
    do_read(21'h000118, rd);
    chk(rd == 0, "R1 width read after reset", rd, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule